// File: doc/BRIEF.md
# Linked descriptor DMA channel

This block is one DMA channel that walks a chain of control blocks kept in a word-addressed memory. Each control block is eight 32-bit words: a 64-bit link to the next block (word offsets 0-1), a 64-bit info word (offsets 2-3), a 64-bit data pointer (offsets 4-5) and a 64-bit status word (offsets 6-7). Only the low word of each is interpreted. One data block is described per control block.

In injection mode the channel reads the bytes of the data block from memory and presents them on an outgoing byte stream. In extraction mode it takes bytes from an incoming byte stream and writes them into the buffer. When a block is finished, the channel writes the status word back with the done flag set. It then reads the link word of the same block afresh. A link with bit 0 set terminates the chain. The channel parks there and stays active. Software may then patch the link in place and pulse reload to resume the walk from the newly linked block. Disable stops the channel. A separate discard strobe forgets a frame that was left half received.

Top module: `chain_dma_channel`

## Requirements
- R1: After reset `active`, `parked`, `irq`, `tx_valid`, `rx_ready` and `mem_req` are all 0.
- R2: On `act_req` while inactive, the channel fetches the control block at byte address `head_lo`. In injection mode (`cfg_extract`=0) it emits status[15:0] bytes starting at byte address dataptr + status[31:20]. The byte at byte address A is bits 8*(A mod 4)+7 down to 8*(A mod 4) of memory word A/4. `tx_valid` holds with stable data until `tx_ready`.
- R3: `tx_sof` is high on the first byte of a block only when status bit 16 is set. `tx_eof` is high on the last byte only when status bit 17 is set.
- R4: After an injected block, the status word (word offset 6) is written back unchanged except that bit 19 (done) is set.
- R5: After each block the link word (offset 0) is read. If its bit 0 is 1, the channel parks: `parked`=1 and `active`=1, and it makes no memory access. Otherwise it continues with the block at the link's byte address.
- R6: A `reload_req` while parked re-reads the link of the same block. It continues if the link is now valid and parks again if it is not. Outside the parked state, reload has no effect.
- R7: In extraction mode, received bytes go to dataptr + status[31:20] + n. The written-back status carries: the received byte count in bits 15:0; bit 16 set when the block starts a frame; bit 17 set when the frame's last byte landed in this block; bits 18 and 31:20 kept as fetched; bit 19 set.
- R8: A frame longer than info[15:0] fills exactly that many bytes with bit 17 clear. The rest of the frame continues in the next block with bit 16 clear.
- R9: `irq` pulses for one cycle right after a status write-back whose bit 18 is set. When `cfg_eof_only`=1, it pulses only if bit 17 of that status is also set.
- R10: `active` is 0 in the cycle after `disable_req`. Partial-frame state survives a disable, so the next extracted block continues without start of frame. `discard_req` clears that state, so the next block starts a frame.
- R11: `act_req` while active is ignored: no new fetch, no stream traffic, and `active` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_extract | input | 1 | 0 = memory to stream, 1 = stream to memory |
| cfg_eof_only | input | 1 | Restrict interrupts to end-of-frame blocks |
| head_lo | input | 32 | Low word of the first control block address |
| head_hi | input | 32 | High word of the first control block address |
| act_req | input | 1 | Start strobe |
| reload_req | input | 1 | Re-read parked link strobe |
| disable_req | input | 1 | Stop strobe |
| discard_req | input | 1 | Drop partial-frame state strobe |
| active | output | 1 | Channel running or parked |
| parked | output | 1 | Waiting on an invalid link |
| irq | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | AW | Word address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| tx_sof | output | 1 | Outgoing byte starts a frame |
| tx_eof | output | 1 | Outgoing byte ends a frame |
| tx_ready | input | 1 | Sink accepts the byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_eof | input | 1 | Incoming byte ends a frame |
| rx_ready | output | 1 | Channel accepts an incoming byte |

## Verification
The properties assume the memory answers every read in the next cycle and never stalls. They assume the strobes are single-cycle pulses, that the mode inputs stay fixed while the channel is active, and that every pointer lies inside the AW-bit word space with control blocks word aligned. The stimulus meets these assumptions. Mode and descriptors change only while the channel is idle or parked, and the stream source holds each byte until `rx_ready` is seen. The injection sweep covers every byte lane and block length from 1 to 5, with and without back-pressure on the sink.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_FREQ, S_FCAP, S_TREQ, S_TCAP, S_TSEND,
    S_RECV, S_WB, S_NREQ, S_NCAP, S_PARK
  } dma_state_t;

  // status word layout, MSB first
  typedef struct packed {
    logic [11:0] offs;
    logic        done;
    logic        intr;
    logic        eof;
    logic        sof;
    logic [15:0] len;
  } blk_status_t;

  // word offsets inside a control block
  localparam int unsigned OFS_LINK = 0;
  localparam int unsigned OFS_INFO = 2;
  localparam int unsigned OFS_STAT = 6;

endpackage

// File: rtl/chain_dma_lane.sv
module chain_dma_lane #(
  parameter int AW = 10
) (
  input  logic [AW+1:0] byte_addr,
  input  logic [31:0]   rd_word,
  input  logic [7:0]    wr_byte,
  output logic [AW-1:0] word_addr,
  output logic [7:0]    rd_byte,
  output logic [31:0]   wr_word,
  output logic [3:0]    wr_be
);
  localparam int LANES = 4;

  logic [1:0] lane;
  assign lane      = byte_addr[1:0];
  assign word_addr = byte_addr[AW+1:2];
  assign rd_byte   = rd_word[lane*8 +: 8];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wr_be[g]          = (lane == 2'(g));
    assign wr_word[8*g +: 8] = wr_byte;
  end
endmodule

// File: rtl/chain_dma_irq.sv
module chain_dma_irq (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic st_intr,
  input  logic st_eof,
  input  logic eof_only,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= fire && st_intr && (!eof_only || st_eof);
  end
endmodule

// File: rtl/chain_dma_channel.sv
module chain_dma_channel
  import chain_dma_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_extract,
  input  logic          cfg_eof_only,
  input  logic [31:0]   head_lo,
  input  logic [31:0]   head_hi,
  input  logic          act_req,
  input  logic          reload_req,
  input  logic          disable_req,
  input  logic          discard_req,
  output logic          active,
  output logic          parked,
  output logic          irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_sof,
  output logic          tx_eof,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_eof,
  output logic          rx_ready
);
  localparam int BAW = AW + 2;

  dma_state_t  state_q;
  logic [AW-1:0]  blk_q;
  logic [1:0]     fidx_q;
  logic [15:0]    info_len_q;
  logic [BAW-1:0] dptr_q;
  blk_status_t    stat_q;
  logic [15:0]    cnt_q;
  logic           eof_seen_q;
  logic           mid_frame_q;
  logic           tx_valid_q, tx_sof_q, tx_eof_q;
  logic [7:0]     tx_data_q;

  logic [BAW-1:0] byte_addr;
  logic [AW-1:0]  lane_word;
  logic [7:0]     rd_byte;
  logic [31:0]    lane_wdata;
  logic [3:0]     lane_be;
  blk_status_t    wb_stat;
  logic           last_tx;
  logic           rx_last;
  logic           unused_hi;

  assign unused_hi = ^{head_hi, head_lo[31:BAW], head_lo[1:0]};

  assign byte_addr = dptr_q + BAW'(stat_q.offs) + BAW'(cnt_q);
  assign last_tx   = (cnt_q + 16'd1 == stat_q.len);
  assign rx_last   = rx_eof || (cnt_q + 16'd1 == info_len_q);

  chain_dma_lane #(.AW(AW)) u_lane (
    .byte_addr (byte_addr),
    .rd_word   (mem_rdata),
    .wr_byte   (rx_data),
    .word_addr (lane_word),
    .rd_byte   (rd_byte),
    .wr_word   (lane_wdata),
    .wr_be     (lane_be)
  );

  // status written back at the end of a block
  always_comb begin
    wb_stat      = stat_q;
    wb_stat.done = 1'b1;
    if (cfg_extract) begin
      wb_stat.len = cnt_q;
      wb_stat.eof = eof_seen_q;
      wb_stat.sof = ~mid_frame_q;
    end
  end

  chain_dma_irq u_irq (
    .clk      (clk),
    .rst      (rst),
    .fire     (state_q == S_WB),
    .st_intr  (wb_stat.intr),
    .st_eof   (wb_stat.eof),
    .eof_only (cfg_eof_only),
    .irq      (irq)
  );

  // memory port, decoded from the state register
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_be    = 4'hF;
    mem_wdata = lane_wdata;
    mem_addr  = blk_q + AW'(OFS_LINK);
    case (state_q)
      S_FREQ: begin
        mem_req  = 1'b1;
        mem_addr = blk_q + AW'(OFS_INFO) + AW'({fidx_q, 1'b0});
      end
      S_TREQ: begin
        mem_req  = 1'b1;
        mem_addr = lane_word;
      end
      S_RECV: begin
        mem_req  = rx_valid;
        mem_we   = rx_valid;
        mem_be   = lane_be;
        mem_addr = lane_word;
      end
      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = wb_stat;
        mem_addr  = blk_q + AW'(OFS_STAT);
      end
      S_NREQ: mem_req = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      blk_q       <= '0;
      fidx_q      <= '0;
      info_len_q  <= '0;
      dptr_q      <= '0;
      stat_q      <= '0;
      cnt_q       <= '0;
      eof_seen_q  <= 1'b0;
      mid_frame_q <= 1'b0;
      tx_valid_q  <= 1'b0;
      tx_data_q   <= '0;
      tx_sof_q    <= 1'b0;
      tx_eof_q    <= 1'b0;
    end else begin
      if (discard_req)
        mid_frame_q <= 1'b0;
      else if (state_q == S_WB && cfg_extract)
        mid_frame_q <= ~eof_seen_q;

      if (disable_req) begin
        state_q    <= S_IDLE;
        tx_valid_q <= 1'b0;
        tx_sof_q   <= 1'b0;
        tx_eof_q   <= 1'b0;
      end else begin
        case (state_q)
          S_IDLE: if (act_req) begin
            blk_q   <= head_lo[BAW-1:2];
            fidx_q  <= '0;
            state_q <= S_FREQ;
          end
          S_FREQ: state_q <= S_FCAP;
          S_FCAP: begin
            case (fidx_q)
              2'd0:    info_len_q <= mem_rdata[15:0];
              2'd1:    dptr_q     <= mem_rdata[BAW-1:0];
              default: stat_q     <= blk_status_t'(mem_rdata);
            endcase
            if (fidx_q == 2'd2) begin
              cnt_q      <= '0;
              eof_seen_q <= 1'b0;
              if (cfg_extract)
                state_q <= (info_len_q == 16'd0) ? S_WB : S_RECV;
              else
                state_q <= (mem_rdata[15:0] == 16'd0) ? S_WB : S_TREQ;
            end else begin
              fidx_q  <= fidx_q + 2'd1;
              state_q <= S_FREQ;
            end
          end
          S_TREQ: state_q <= S_TCAP;
          S_TCAP: begin
            tx_valid_q <= 1'b1;
            tx_data_q  <= rd_byte;
            tx_sof_q   <= stat_q.sof && (cnt_q == 16'd0);
            tx_eof_q   <= stat_q.eof && last_tx;
            state_q    <= S_TSEND;
          end
          S_TSEND: if (tx_ready) begin
            tx_valid_q <= 1'b0;
            tx_sof_q   <= 1'b0;
            tx_eof_q   <= 1'b0;
            if (last_tx) state_q <= S_WB;
            else begin
              cnt_q   <= cnt_q + 16'd1;
              state_q <= S_TREQ;
            end
          end
          S_RECV: if (rx_valid) begin
            cnt_q <= cnt_q + 16'd1;
            if (rx_last) begin
              eof_seen_q <= rx_eof;
              state_q    <= S_WB;
            end
          end
          S_WB:   state_q <= S_NREQ;
          S_NREQ: state_q <= S_NCAP;
          S_NCAP: begin
            if (mem_rdata[0]) state_q <= S_PARK;
            else begin
              blk_q   <= mem_rdata[BAW-1:2];
              fidx_q  <= '0;
              state_q <= S_FREQ;
            end
          end
          S_PARK: if (reload_req) state_q <= S_NREQ;
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign active   = (state_q != S_IDLE);
  assign parked   = (state_q == S_PARK);
  assign rx_ready = (state_q == S_RECV);
  assign tx_valid = tx_valid_q;
  assign tx_data  = tx_data_q;
  assign tx_sof   = tx_sof_q;
  assign tx_eof   = tx_eof_q;
endmodule

// File: rtl/chain_dma_checker.sv
module chain_dma_checker (
  input logic       clk,
  input logic       rst,
  input logic       act_req,
  input logic       reload_req,
  input logic       disable_req,
  input logic       active,
  input logic       parked,
  input logic       irq,
  input logic       mem_req,
  input logic       mem_we,
  input logic [3:0] mem_be,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_ready,
  input logic       rx_ready
);
  // R10: disable takes effect on the next cycle
  a_r10_disable_stops: assert property (@(posedge clk) disable iff (rst)
    disable_req |=> !active);

  // R5: parking keeps the channel active
  a_r5_parked_active: assert property (@(posedge clk) disable iff (rst)
    parked |-> active);

  // R9: interrupt follows a full-word status write
  a_r9_irq_after_wb: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(mem_we && mem_be == 4'hF));

  // R2: outgoing byte held until accepted
  a_r2_tx_hold: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready && !disable_req |=> tx_valid && $stable(tx_data));

  // R6: reload while parked issues the link read
  a_r6_reload_reads: assert property (@(posedge clk) disable iff (rst)
    parked && reload_req && !disable_req |=> !parked && mem_req && !mem_we);

  // R11: activate while active does not stop the channel
  a_r11_act_ignored: assert property (@(posedge clk) disable iff (rst)
    active && act_req && !disable_req |=> active);

  // R7: the two stream directions are never busy together
  a_r7_dir_excl: assert property (@(posedge clk) disable iff (rst)
    !(rx_ready && tx_valid));

  // R1: a write is always a request
  a_r1_we_req: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req);
endmodule

bind chain_dma_channel chain_dma_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .act_req     (act_req),
  .reload_req  (reload_req),
  .disable_req (disable_req),
  .active      (active),
  .parked      (parked),
  .irq         (irq),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_be      (mem_be),
  .tx_valid    (tx_valid),
  .tx_data     (tx_data),
  .tx_ready    (tx_ready),
  .rx_ready    (rx_ready)
);

// File: tb/chain_dma_channel_tb.sv
module chain_dma_channel_tb;
  localparam int CLK_P = 10;
  localparam int AW    = 10;
  localparam logic [31:0] DONE = 32'h0008_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_extract = 1'b0, cfg_eof_only = 1'b0;
  logic [31:0] head_lo = '0, head_hi = '0;
  logic act_req = 1'b0, reload_req = 1'b0, disable_req = 1'b0, discard_req = 1'b0;
  logic active, parked, irq;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic tx_valid, tx_sof, tx_eof;
  logic [7:0] tx_data;
  logic tx_ready = 1'b1;
  logic rx_valid = 1'b0, rx_eof = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_ready;

  always #(CLK_P/2) clk = ~clk;

  chain_dma_channel #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .cfg_extract(cfg_extract), .cfg_eof_only(cfg_eof_only),
    .head_lo(head_lo), .head_hi(head_hi), .act_req(act_req), .reload_req(reload_req),
    .disable_req(disable_req), .discard_req(discard_req), .active(active),
    .parked(parked), .irq(irq), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_eof(rx_eof), .rx_ready(rx_ready)
  );

  // memory model: one-cycle read latency, byte-enabled writes
  logic [31:0] mem [0:(1<<AW)-1];
  int acc_cnt = 0;
  always @(posedge clk) begin
    if (mem_req === 1'b1) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else mem_rdata <= mem[mem_addr];
    end
  end

  // stream sink and interrupt monitor
  int cyc = 0, got_n = 0, irq_cnt = 0;
  logic bp = 1'b0;
  logic [7:0] got_d [0:255];
  logic got_s [0:255];
  logic got_e [0:255];
  always @(negedge clk) begin
    cyc++;
    tx_ready = bp ? cyc[0] : 1'b1;
    if (!rst && tx_valid && tx_ready && got_n < 256) begin
      got_d[got_n] = tx_data;
      got_s[got_n] = tx_sof;
      got_e[got_n] = tx_eof;
      got_n++;
    end
    if (!rst && irq) irq_cnt++;
  end

  int checks = 0, errors = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  function automatic logic [31:0] mk_st(input int len, input bit sof, input bit eof,
                                        input bit intr, input int offs);
    return (32'(offs) << 20) | (32'(intr) << 18) | (32'(eof) << 17)
         | (32'(sof) << 16) | 32'(len);
  endfunction

  task automatic set_byte(input int a, input logic [7:0] v);
    mem[a >> 2][(a & 3) * 8 +: 8] = v;
  endtask

  function automatic logic [7:0] get_byte(input int a);
    return mem[a >> 2][(a & 3) * 8 +: 8];
  endfunction

  task automatic dcb(input int w, input int nxt, input int info,
                     input int dptr, input logic [31:0] st);
    mem[w]   = 32'(nxt);  mem[w+1] = '0;
    mem[w+2] = 32'(info); mem[w+3] = '0;
    mem[w+4] = 32'(dptr); mem[w+5] = '0;
    mem[w+6] = st;        mem[w+7] = '0;
  endtask

  task automatic do_act(input int head);
    head_lo = 32'(head); head_hi = 32'h0;
    act_req = 1'b1; @(negedge clk); act_req = 1'b0;
  endtask
  task automatic do_reload;
    reload_req = 1'b1; @(negedge clk); reload_req = 1'b0;
  endtask
  task automatic do_disable;
    disable_req = 1'b1; @(negedge clk); disable_req = 1'b0;
  endtask
  task automatic do_discard;
    discard_req = 1'b1; @(negedge clk); discard_req = 1'b0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_parked;
    int n = 0;
    while (!parked && n < 3000) begin @(negedge clk); n++; end
  endtask

  task automatic rx_byte(input logic [7:0] d, input logic e);
    int n = 0;
    rx_valid = 1'b1; rx_data = d; rx_eof = e;
    while (!rx_ready && n < 3000) begin @(negedge clk); n++; end
    @(negedge clk);
    rx_valid = 1'b0; rx_eof = 1'b0;
  endtask

  task automatic wait_done(input int w);
    int n = 0;
    while (!mem[w][19] && n < 3000) begin @(negedge clk); n++; end
  endtask

  // extraction run that leaves a frame half received, then disables
  task automatic run_partial(input bit disc, input bit exp_sof);
    dcb(120, 512, 4, 32'hB00, 32'h0);
    dcb(128, 1, 8, 32'hB40, 32'h0);
    do_act(480);
    for (int i = 0; i < 4; i++) rx_byte(8'(8'h10 + i), 1'b0);
    wait_done(126);
    chk("R8", "full block without end of frame", mem[126], mk_st(4, 1, 0, 0, 0) | DONE);
    idle(3);
    do_disable;
    if (disc) do_discard;
    dcb(128, 1, 8, 32'hB40, 32'h0);
    do_act(512);
    rx_byte(8'h20, 1'b0);
    rx_byte(8'h21, 1'b1);
    wait_parked;
    chk("R10", disc ? "start of frame after discard" : "continuation kept over disable",
        mem[134], mk_st(2, exp_sof, 1, 0, 0) | DONE);
    do_disable;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int mism, acc0, n0;
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    for (int a = 1024; a < 2048; a++) set_byte(a, pat(a));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1", "active", 32'(active), 0);
    chk("R1", "parked", 32'(parked), 0);
    chk("R1", "irq", 32'(irq), 0);
    chk("R1", "tx_valid", 32'(tx_valid), 0);
    chk("R1", "rx_ready", 32'(rx_ready), 0);
    chk("R1", "mem_req", 32'(mem_req), 0);

    // two-block injection chain under back-pressure
    dcb(64, 288, 0, 32'h401, mk_st(5, 1, 0, 1, 2));
    dcb(72, 1, 0, 32'h500, mk_st(3, 0, 1, 1, 0));
    bp = 1'b1; got_n = 0; irq_cnt = 0;
    do_act(256);
    wait_parked;
    bp = 1'b0;
    chk("R2", "byte count", 32'(got_n), 8);
    mism = 0;
    for (int i = 0; i < 8; i++) begin
      if (got_d[i] !== pat(i < 5 ? 1027 + i : 1280 + i - 5)) mism++;
    end
    chk("R2", "data mismatches", 32'(mism), 0);
    mism = 0;
    for (int i = 0; i < 8; i++) begin
      if (got_s[i] !== (i == 0)) mism++;
      if (got_e[i] !== (i == 7)) mism++;
    end
    chk("R3", "frame marker mismatches", 32'(mism), 0);
    chk("R4", "first status write-back", mem[70], mk_st(5, 1, 0, 1, 2) | DONE);
    chk("R4", "second status write-back", mem[78], mk_st(3, 0, 1, 1, 0) | DONE);
    chk("R9", "interrupts, every block", 32'(irq_cnt), 2);
    chk("R5", "parked", 32'(parked), 1);
    chk("R5", "active while parked", 32'(active), 1);
    acc0 = acc_cnt;
    idle(20);
    chk("R5", "no memory access while parked", 32'(acc_cnt - acc0), 0);

    // reload with the link still invalid, then after patching it
    do_reload;
    idle(10);
    chk("R6", "parks again on invalid link", 32'(parked), 1);
    chk("R6", "no bytes on invalid reload", 32'(got_n), 8);
    dcb(80, 1, 0, 32'h580, mk_st(2, 1, 1, 0, 0));
    mem[72] = 32'd320;
    do_reload;
    wait_parked;
    chk("R6", "bytes after patched reload", 32'(got_n), 10);
    chk("R6", "patched block data", {got_d[8], got_d[9]}, {pat(1408), pat(1409)});
    chk("R4", "patched block status", mem[86], mk_st(2, 1, 1, 0, 0) | DONE);
    chk("R9", "no interrupt without request bit", 32'(irq_cnt), 2);

    // activate while active
    acc0 = acc_cnt; n0 = got_n;
    do_act(256);
    idle(40);
    chk("R11", "no traffic", 32'(got_n - n0), 0);
    chk("R11", "no memory access", 32'(acc_cnt - acc0), 0);
    chk("R11", "still parked", 32'(parked), 1);

    // disable
    do_disable;
    chk("R10", "active after disable", 32'(active), 0);
    chk("R10", "parked after disable", 32'(parked), 0);
    do_reload;
    idle(5);
    chk("R6", "reload while idle has no effect", 32'(active), 0);

    // sweep: every lane, lengths 1..5
    for (int len = 1; len <= 5; len++) begin
      for (int ln = 0; ln < 4; ln++) begin
        logic [7:0] seed;
        seed = 8'(len * 16 + ln);
        for (int a = 1536; a < 1548; a++) set_byte(a, pat(a) ^ seed);
        dcb(88, 1, 0, 1536 + ln, mk_st(len, 1, 1, 0, 0));
        bp = ln[0];
        got_n = 0;
        do_act(352);
        wait_parked;
        mism = (got_n == len) ? 0 : 100;
        for (int i = 0; i < len; i++) begin
          if (got_d[i] !== (pat(1536 + ln + i) ^ seed)) mism++;
          if (got_s[i] !== (i == 0)) mism++;
          if (got_e[i] !== (i == len - 1)) mism++;
        end
        chk("R2", $sformatf("sweep len %0d lane %0d", len, ln), 32'(mism), 0);
        do_disable;
      end
    end
    bp = 1'b0;

    // extraction, interrupts only on end of frame
    cfg_extract = 1'b1; cfg_eof_only = 1'b1;
    for (int w = 512; w < 768; w++) mem[w] = 32'hEEEE_EEEE;
    dcb(96, 416, 16, 32'h803, mk_st(0, 0, 0, 1, 1));
    dcb(104, 448, 6, 32'h900, mk_st(0, 0, 0, 1, 0));
    dcb(112, 1, 16, 32'hA00, mk_st(0, 0, 0, 1, 0));
    irq_cnt = 0;
    do_act(384);
    for (int i = 0; i < 5; i++) rx_byte(8'(8'h40 + i), i == 4);
    for (int i = 0; i < 9; i++) rx_byte(8'(8'h80 + i), i == 8);
    wait_parked;
    chk("R7", "short frame status", mem[102], mk_st(5, 1, 1, 1, 1) | DONE);
    mism = 0;
    for (int i = 0; i < 5; i++) if (get_byte(2052 + i) !== 8'(8'h40 + i)) mism++;
    chk("R7", "short frame bytes", 32'(mism), 0);
    chk("R7", "byte before buffer untouched", 32'(get_byte(2051)), 32'hEE);
    chk("R7", "byte after frame untouched", 32'(get_byte(2057)), 32'hEE);
    chk("R8", "truncated block status", mem[110], mk_st(6, 1, 0, 1, 0) | DONE);
    chk("R8", "continuation status", mem[118], mk_st(3, 0, 1, 1, 0) | DONE);
    mism = 0;
    for (int i = 0; i < 6; i++) if (get_byte(2304 + i) !== 8'(8'h80 + i)) mism++;
    for (int i = 0; i < 3; i++) if (get_byte(2560 + i) !== 8'(8'h86 + i)) mism++;
    chk("R8", "split frame bytes", 32'(mism), 0);
    chk("R8", "byte after continuation untouched", 32'(get_byte(2563)), 32'hEE);
    chk("R9", "interrupts, end-of-frame only", 32'(irq_cnt), 2);
    do_disable;

    // partial frame over disable, without and with discard
    cfg_eof_only = 1'b0;
    run_partial(1'b0, 1'b0);
    run_partial(1'b1, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule